// File: doc/BRIEF.md
# Microstep Position Indexer

This block keeps track of the electrical excitation angle of a two-winding bipolar stepper motor and turns it into a pair of signed current set-points, one per winding. Each rising edge on the step input moves the angle by one step of the selected resolution. The direction input chooses which way it moves. A 3-bit resolution select chooses among eight step sizes, from full step down to 1/128 step. The set-points are percentages of full-scale current, from −100 to +100. They are taken from a quarter-wave sine table that is built when the design is elaborated. The table feeds an external current regulator.

Internally the angle is a 9-bit index over 512 finest steps per electrical cycle, which is 128 per quarter. Winding A carries the cosine of the angle and winding B the sine. At the finer resolutions the index moves by a power of two. Full-step mode sits on the 45° points of each quarter and drives both windings at 100%. A change of resolution takes effect at the next step edge and snaps the index onto the grid of the new resolution.

The block also has a home indicator and a hold-current request. The hold request rises after a programmable number of clock cycles without a step edge. It also has a synchronous sleep input, a synchronous index-clear input and an amplitude enable.

Top module: `ustep_indexer`

## Requirements
- R1: Each rising edge of `step_in` moves the index by exactly one step of the selected resolution. With no edge the index and the outputs hold. The step input is resynchronised, so the outputs change on the third rising clock edge after `step_in` goes high.
- R2: `mode_sel` selects the step size in finest-index units: 1 = 64 (half), 2 = 32, 3 = 16, 4 = 8, 5 = 4, 6 = 2, 7 = 1 (1/128). 0 is full step (128 units, on the 45° points).
- R3: At finer resolutions, `wind_a` is 100·cos and `wind_b` is 100·sin of the angle index·360°/512, to within one unit. Both are 8-bit two's complement. Both are exactly 0 or ±100 at the quarter points.
- R4: Home is index 0 (`wind_a` = +100, `wind_b` = 0) at the finer resolutions. In full step, home is index 448 (+100 / −100), and every full-step position drives ±100 on both windings.
- R5: With `dir_in` low the index increases, so winding B lags winding A by 90°. With `dir_in` high the index decreases. Direction may change at any step.
- R6: While `clr_n` is low the index is held at the home position of `mode_sel`, and step edges are ignored.
- R7: While `sleep_n` is low all state returns to its initial value: the index goes home, the hold request goes low, and `drive_on` and both winding outputs are 0.
- R8: With `amp_en` low, `drive_on` and both winding outputs are 0, but step edges still move the index. Raising `amp_en` shows the moved position.
- R9: When the resolution is changed between two finer modes, the next step goes to the nearest grid point of the new resolution in the step direction.
- R10: When the resolution is changed from a finer mode to full step, the next step goes to the 45° point of the present quarter (quarter base + 64). If the index is already on such a point, it moves by ±128.
- R11: When the resolution is changed from full step to a finer mode, the next step goes to the next grid point of the new resolution in the step direction.
- R12: `at_home` is high exactly when the index equals the home position of the resolution in effect.
- R13: `hold_req` rises after `HOLD_CYCLES` clock cycles with no step edge, and clears at the clock edge that follows the next step edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sleep_n | input | 1 | Synchronous sleep, active low; clears all state |
| clr_n | input | 1 | Synchronous index clear to home, active low |
| amp_en | input | 1 | Amplitude enable; low turns the outputs off |
| step_in | input | 1 | Asynchronous step pulse; rising edge advances |
| dir_in | input | 1 | 0 = increasing index, 1 = decreasing |
| mode_sel | input | 3 | Resolution select, 0 = full … 7 = 1/128 |
| wind_a | output | 8 | Winding A set-point, signed percent |
| wind_b | output | 8 | Winding B set-point, signed percent |
| drive_on | output | 1 | High while the set-points are live |
| at_home | output | 1 | Index is at the home position |
| hold_req | output | 1 | No step edge for HOLD_CYCLES cycles |

## Verification
A wrong index shows up at the set-point outputs on the third clock edge after the step that produced it. The error stays visible in every later position, because there is no re-zeroing except through clear or sleep. An index off the grid of the active resolution, or a snap made in the wrong direction, appears as a pair of amplitudes that does not match the cosine and sine of the expected angle. The same fault usually also appears as a home flag at the wrong moment within one electrical cycle. A hold counter that is not reset shows up as `hold_req` being high in the middle of a step sequence, or staying high after a step edge.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int QBITS  = 7;
  localparam int IDX_W  = QBITS + 2;
  localparam int QSTEPS = 1 << QBITS;
  localparam int MODE_W = 3;
  localparam int PCT_W  = 7;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [PCT_W-1:0]  pct_t;

  localparam mode_t MODE_FULL = '0;

  // Rational sine approximation over a half period of 2*QSTEPS units,
  // rounded to an integer percent. Used only at elaboration time.
  function automatic int amp_pct(input int k);
    int h;
    int p;
    int d;
    h = 2 * QSTEPS;
    p = k * (h - k);
    d = (5 * h * h) / 4 - p;
    return (800 * p + d) / (2 * d);
  endfunction

  // Index distance covered by one step of a resolution.
  function automatic idx_t step_span(input mode_t m);
    if (m == MODE_FULL) return idx_t'(QSTEPS);
    return idx_t'(1) << (QBITS - int'(m));
  endfunction

  // Home index: zero angle for the finer modes, -45 degrees for full step.
  function automatic idx_t home_idx(input mode_t m);
    if (m == MODE_FULL) return idx_t'(3 * QSTEPS + QSTEPS / 2);
    return '0;
  endfunction

  // Next index for one step, including the snap on a resolution change.
  function automatic idx_t next_idx(input idx_t cur, input mode_t m, input logic rev);
    idx_t span;
    idx_t mask;
    idx_t base;
    if (m == MODE_FULL) begin
      if (cur[QBITS-1:0] == QBITS'(QSTEPS / 2))
        return rev ? idx_t'(cur - idx_t'(QSTEPS)) : idx_t'(cur + idx_t'(QSTEPS));
      return (cur & ~idx_t'(QSTEPS - 1)) | idx_t'(QSTEPS / 2);
    end
    span = step_span(m);
    mask = span - idx_t'(1);
    base = cur & ~mask;
    if (!rev) return idx_t'(base + span);
    if ((cur & mask) != '0) return base;
    return idx_t'(cur - span);
  endfunction
endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic sleep_n,
  input  logic step_in,
  output logic step_rise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!sleep_n) chain <= '0;
        else          chain <= step_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!sleep_n) chain <= '0;
        else          chain <= {chain[SYNC_STAGES-2:0], step_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!sleep_n) last_q <= 1'b0;
    else          last_q <= chain[SYNC_STAGES-1];
  end

  assign step_rise = chain[SYNC_STAGES-1] & ~last_q;

  // R1: a held-high step input yields a single advance pulse
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!sleep_n)
    step_rise |=> !step_rise);
endmodule

// File: rtl/pos_track.sv
module pos_track
  import ustep_pkg::*;
(
  input  logic  clk,
  input  logic  sleep_n,
  input  logic  clr_n,
  input  logic  step_rise,
  input  logic  dir_in,
  input  mode_t mode_sel,
  output idx_t  idx,
  output mode_t mode_q,
  output logic  at_home
);
  always_ff @(posedge clk) begin
    if (!sleep_n || !clr_n) begin
      idx    <= home_idx(mode_sel);
      mode_q <= mode_sel;
    end else if (step_rise) begin
      idx    <= next_idx(idx, mode_sel, dir_in);
      mode_q <= mode_sel;
    end
  end

  assign at_home = (idx == home_idx(mode_q));

  p_hold_pos_r1: assert property (@(posedge clk) disable iff (!sleep_n)
    (clr_n && !step_rise) |=> $stable(idx));

  p_clear_home_r6: assert property (@(posedge clk) disable iff (!sleep_n)
    !clr_n |=> at_home);

  p_full_grid_r10: assert property (@(posedge clk) disable iff (!sleep_n)
    (mode_q == MODE_FULL) |-> (idx[QBITS-1:0] == QBITS'(QSTEPS / 2)));

  p_fine_grid_r9: assert property (@(posedge clk) disable iff (!sleep_n)
    (clr_n && step_rise && mode_sel != MODE_FULL)
      |=> ((idx & (step_span(mode_q) - idx_t'(1))) == '0));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_CYCLES = 1000
) (
  input  logic clk,
  input  logic sleep_n,
  input  logic step_rise,
  output logic hold_req
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!sleep_n) begin
      idle_cnt <= '0;
      hold_req <= 1'b0;
    end else if (step_rise) begin
      idle_cnt <= '0;
      hold_req <= 1'b0;
    end else begin
      if (idle_cnt != CW'(HOLD_CYCLES)) idle_cnt <= idle_cnt + CW'(1);
      if (idle_cnt == CW'(HOLD_CYCLES - 1)) hold_req <= 1'b1;
    end
  end

  p_hold_clear_r13: assert property (@(posedge clk) disable iff (!sleep_n)
    step_rise |=> !hold_req);
endmodule

// File: rtl/phase_map.sv
module phase_map
  import ustep_pkg::*;
#(
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             sleep_n,
  input  idx_t             idx,
  input  mode_t            mode_q,
  input  logic             drive_on,
  output logic [AMP_W-1:0] wind_a,
  output logic [AMP_W-1:0] wind_b
);
  localparam pct_t FULL_PCT = pct_t'(amp_pct(QSTEPS));

  pct_t rom [0:QSTEPS];
  generate
    for (genvar g = 0; g <= QSTEPS; g++) begin : g_rom
      assign rom[g] = pct_t'(amp_pct(g));
    end
  endgenerate

  logic [1:0]       quad;
  logic [QBITS:0]   k_fw;
  logic [QBITS:0]   k_bw;
  pct_t             mag_a;
  pct_t             mag_b;
  logic             neg_a;
  logic             neg_b;
  logic [AMP_W-1:0] ext_a;
  logic [AMP_W-1:0] ext_b;

  always_comb begin
    quad  = idx[IDX_W-1 -: 2];
    k_fw  = {1'b0, idx[QBITS-1:0]};
    k_bw  = (QBITS+1)'(QSTEPS) - k_fw;
    neg_a = quad[0] ^ quad[1];
    neg_b = quad[1];
    if (mode_q == MODE_FULL) begin
      mag_a = FULL_PCT;
      mag_b = FULL_PCT;
    end else begin
      mag_a = quad[0] ? rom[k_fw] : rom[k_bw];
      mag_b = quad[0] ? rom[k_bw] : rom[k_fw];
    end
    ext_a  = AMP_W'(mag_a);
    ext_b  = AMP_W'(mag_b);
    wind_a = drive_on ? (neg_a ? -ext_a : ext_a) : '0;
    wind_b = drive_on ? (neg_b ? -ext_b : ext_b) : '0;
  end

  p_amp_range_r3: assert property (@(posedge clk) disable iff (!sleep_n)
    drive_on |-> ($signed(wind_a) <= 100 && $signed(wind_a) >= -100 &&
                  $signed(wind_b) <= 100 && $signed(wind_b) >= -100));

  p_full_mag_r4: assert property (@(posedge clk) disable iff (!sleep_n)
    (drive_on && mode_q == MODE_FULL) |->
      (($signed(wind_a) == 100 || $signed(wind_a) == -100) &&
       ($signed(wind_b) == 100 || $signed(wind_b) == -100)));
endmodule

// File: rtl/ustep_indexer.sv
module ustep_indexer
  import ustep_pkg::*;
#(
  parameter int AMP_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             sleep_n,
  input  logic             clr_n,
  input  logic             amp_en,
  input  logic             step_in,
  input  logic             dir_in,
  input  logic [2:0]       mode_sel,
  output logic [AMP_W-1:0] wind_a,
  output logic [AMP_W-1:0] wind_b,
  output logic             drive_on,
  output logic             at_home,
  output logic             hold_req
);
  logic  step_rise;
  idx_t  idx;
  mode_t mode_q;

  assign drive_on = amp_en & sleep_n;

  step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .sleep_n(sleep_n), .step_in(step_in), .step_rise(step_rise)
  );

  pos_track u_pos (
    .clk(clk), .sleep_n(sleep_n), .clr_n(clr_n), .step_rise(step_rise),
    .dir_in(dir_in), .mode_sel(mode_sel), .idx(idx), .mode_q(mode_q),
    .at_home(at_home)
  );

  hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .sleep_n(sleep_n), .step_rise(step_rise), .hold_req(hold_req)
  );

  phase_map #(.AMP_W(AMP_W)) u_map (
    .clk(clk), .sleep_n(sleep_n), .idx(idx), .mode_q(mode_q),
    .drive_on(drive_on), .wind_a(wind_a), .wind_b(wind_b)
  );

  p_sleep_off_r7: assert property (@(posedge clk)
    !sleep_n |=> (!hold_req && at_home));
endmodule

// File: tb/test_ustep_indexer.sv
`timescale 1ns/1ps
module test_ustep_indexer;
  localparam int HOLD = 64;
  localparam real PI = 3.14159265358979;

  logic       clk = 0;
  logic       sleep_n = 0, clr_n = 1, amp_en = 1, step_in = 0, dir_in = 0;
  logic [2:0] mode_sel = 3'd7;
  logic [7:0] wind_a, wind_b;
  logic       drive_on, at_home, hold_req;

  int n_chk = 0, n_err = 0;
  int mpos = 0, mmode = 7;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  ustep_indexer #(.HOLD_CYCLES(HOLD)) i_ustep_indexer (
    .clk(clk), .sleep_n(sleep_n), .clr_n(clr_n), .amp_en(amp_en),
    .step_in(step_in), .dir_in(dir_in), .mode_sel(mode_sel),
    .wind_a(wind_a), .wind_b(wind_b), .drive_on(drive_on),
    .at_home(at_home), .hold_req(hold_req)
  );

  task automatic chk(input string req, input int act, input int exp, input int tol);
    n_chk++;
    if (act - exp > tol || exp - act > tol) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_home(input int m);
    return (m == 0) ? 448 : 0;
  endfunction

  function automatic int m_amp(input int p, input bit sine, input int m);
    real a, v;
    a = 2.0 * PI * p / 512.0;
    v = sine ? $sin(a) : $cos(a);
    if (m == 0) return (v > 0.0) ? 100 : -100;
    return int'(100.0 * v);
  endfunction

  function automatic int m_next(input int p, input int m, input bit rev);
    int s, q;
    if (m == 0) begin
      if (p % 128 == 64) return rev ? (p + 384) % 512 : (p + 128) % 512;
      return p - p % 128 + 64;
    end
    s = 128 >> m;
    q = p;
    do q = rev ? (q + 511) % 512 : (q + 1) % 512; while (q % s != 0);
    return q;
  endfunction

  task automatic check_out(input string tag);
    int tol;
    tol = (mmode == 0) ? 0 : 1;
    chk({tag, " R3 wind_a"}, $signed(wind_a), m_amp(mpos, 0, mmode), tol);
    chk({tag, " R3 wind_b"}, $signed(wind_b), m_amp(mpos, 1, mmode), tol);
    chk({tag, " R12 at_home"}, at_home, (mpos == m_home(mmode)) ? 1 : 0, 0);
  endtask

  task automatic do_step(input bit upd);
    @(negedge clk) step_in = 1;
    repeat (4) @(negedge clk);
    step_in = 0;
    repeat (4) @(negedge clk);
    if (upd) begin
      mpos = m_next(mpos, int'(mode_sel), dir_in);
      mmode = int'(mode_sel);
    end
  endtask

  task automatic step_chk(input string tag);
    do_step(1);
    check_out(tag);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    // R7: sleep state
    repeat (4) @(negedge clk);
    chk("R7 drive_on in sleep", drive_on, 0, 0);
    chk("R7 wind_a in sleep", $signed(wind_a), 0, 0);
    chk("R7 hold in sleep", hold_req, 0, 0);
    sleep_n = 1;
    repeat (2) @(negedge clk);
    mpos = 0; mmode = 7;
    chk("R4 reset home wind_a", $signed(wind_a), 100, 0);
    chk("R4 reset home wind_b", $signed(wind_b), 0, 0);
    chk("R12 reset at_home", at_home, 1, 0);
    chk("R8 drive_on live", drive_on, 1, 0);

    // R1 R2 R5: full forward cycle in every finer mode
    for (int m = 7; m >= 1; m--) begin
      mode_sel = 3'(m);
      for (int i = 0; i < (512 >> (7 - m)); i++) step_chk("R1 R2 R5 fwd");
      chk("R2 back at home after a cycle", mpos, 0, 0);
    end
    chk("R13 no hold while stepping", hold_req, 0, 0);

    // R5: reverse sweep
    dir_in = 1; mode_sel = 3'd3;
    for (int i = 0; i < 40; i++) step_chk("R5 rev");

    // R10 R4: into full step, then walk it both ways
    mode_sel = 3'd0; dir_in = 0;
    step_chk("R10 snap to full");
    for (int i = 0; i < 6; i++) step_chk("R4 full fwd");
    dir_in = 1;
    for (int i = 0; i < 5; i++) step_chk("R4 full rev");

    // R11: full to quarter, both directions
    mode_sel = 3'd2; dir_in = 0;
    step_chk("R11 full->quarter fwd");
    mode_sel = 3'd0; step_chk("R10 quarter->full");
    mode_sel = 3'd5; dir_in = 1;
    step_chk("R11 full->1/32 rev");

    // R9: misaligned fine position switched to coarser mode
    mode_sel = 3'd7; dir_in = 0;
    for (int i = 0; i < 5; i++) step_chk("R9 fine fwd");
    mode_sel = 3'd4; step_chk("R9 fine->1/16 fwd");
    mode_sel = 3'd7; for (int i = 0; i < 3; i++) step_chk("R9 fine fwd");
    mode_sel = 3'd3; dir_in = 1; step_chk("R9 fine->1/8 rev");
    mode_sel = 3'd7; dir_in = 0; for (int i = 0; i < 3; i++) step_chk("R9 fine fwd");
    mode_sel = 3'd0; step_chk("R10 fine->full");

    // R9 R10 R11 R5: pseudo-random mix of modes and directions
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mode_sel = lf[2:0];
      dir_in = lf[5];
      step_chk("R9 R10 R11 mix");
    end

    // R6: clear ignores steps
    mode_sel = 3'd6; dir_in = 0;
    step_chk("R6 pre");
    @(negedge clk) clr_n = 0;
    do_step(0); do_step(0);
    mpos = 0; mmode = 6;
    check_out("R6 clear holds home");
    mode_sel = 3'd0;
    repeat (2) @(negedge clk);
    mpos = 448; mmode = 0;
    chk("R6 R4 full home wind_a", $signed(wind_a), 100, 0);
    chk("R6 R4 full home wind_b", $signed(wind_b), -100, 0);
    chk("R6 R12 full home flag", at_home, 1, 0);
    clr_n = 1;
    mode_sel = 3'd6;
    step_chk("R6 after release");

    // R8: enable off, position still moves
    amp_en = 0;
    @(negedge clk);
    chk("R8 drive_on off", drive_on, 0, 0);
    do_step(1); do_step(1); do_step(1);
    chk("R8 wind_a off", $signed(wind_a), 0, 0);
    chk("R8 wind_b off", $signed(wind_b), 0, 0);
    amp_en = 1;
    @(negedge clk);
    check_out("R8 moved while off");

    // R13: hold request timing
    step_chk("R13 pre");
    repeat (40) @(negedge clk);
    chk("R13 hold before timeout", hold_req, 0, 0);
    repeat (30) @(negedge clk);
    chk("R13 hold after timeout", hold_req, 1, 0);
    step_chk("R13 step");
    chk("R13 hold cleared by step", hold_req, 0, 0);
    repeat (80) @(negedge clk);
    chk("R13 hold again", hold_req, 1, 0);

    // R7: sleep mid-run resets everything
    mode_sel = 3'd5;
    step_chk("R7 pre");
    sleep_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R7 drive_on", drive_on, 0, 0);
    chk("R7 wind_b", $signed(wind_b), 0, 0);
    chk("R7 hold cleared", hold_req, 0, 0);
    sleep_n = 1;
    @(negedge clk);
    mpos = 0; mmode = 5;
    check_out("R7 home after sleep");

    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule